// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic-Logic Unit

This block evaluates one arithmetic or logical function on two signed operand words. The function is chosen in two steps. A 2-bit class code from the instruction's main decoder picks a fixed add or a fixed subtract, or it hands the choice to the 6-bit function field of a register-format instruction. Both steps turn into one small control word: invert A, invert B, and a 2-bit output selector. That control word steers a single datapath built from a bitwise AND, a bitwise OR, an adder and a set-on-less-than path.

Subtract, NOR and the signed comparison are not separate circuits. They come from inverting the inputs in front of the same AND/OR/adder core. Setting the B-invert bit also sets the adder's carry-in, so the adder computes A plus the two's complement of B. The outputs are the result word, a zero flag, a signed-overflow flag and an invalid-function flag. All four are registered, so they appear one clock after the inputs are sampled.

Top module: `alu2lvl_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four outputs are 0 after that edge.
- R2: Every output reflects the inputs sampled at the previous rising edge, with exactly one cycle of latency.
- R3: With `op_class` = 2'b00 the result is A + B (modulo 2^W), whatever `func_code` holds.
- R4: With `op_class` = 2'b01 the result is A − B (modulo 2^W), whatever `func_code` holds.
- R5: With `op_class` = 2'b10, `func_code` 32 gives A + B and `func_code` 34 gives A − B.
- R6: With `op_class` = 2'b10, `func_code` 36 gives A & B, 37 gives A | B and 39 gives ~(A | B).
- R7: With `op_class` = 2'b10 and `func_code` 42, the result is 1 when A < B as two's-complement values and 0 otherwise, with all upper bits 0. The answer is correct even when A − B overflows.
- R8: `zero_q` is 1 exactly when the registered result word is all zeros. This includes the invalid case and excludes the reset state.
- R9: `ovf_q` is 1 only for add or subtract whose signed result does not fit in W bits. It is always 0 for AND, OR, NOR and set-less-than.
- R10: `op_class` = 2'b11, or `op_class` = 2'b10 with a `func_code` outside {32, 34, 36, 37, 39, 42}, sets `bad_fn_q` to 1, `res_q` to 0 and `ovf_q` to 0, so `zero_q` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | Class code from the main decoder |
| func_code | input | 6 | Function field, used when op_class = 2'b10 |
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| res_q | output | W | Registered result |
| zero_q | output | 1 | Registered all-zero flag |
| ovf_q | output | 1 | Registered signed-overflow flag |
| bad_fn_q | output | 1 | Registered invalid-function flag |

## Verification
The fixed classes are driven with function fields that name another operation. This shows whether the class code really overrides the function field.

Operand pairs are chosen around the sign boundary: largest positive with 1, most negative minus 1, and equal values. These cases separate a correct adder carry-in from a missing one, true signed overflow from an unsigned carry, and an overflow-corrected set-less-than from a raw sign test.

Mixed bit patterns such as 0xF0F0… against 0x0FF0… separate AND, OR and NOR from one another. Unused function codes next to valid ones show that the decode is exact rather than a partial bit match.

// File: rtl/alu2lvl_pkg.sv
package alu2lvl_pkg;

  localparam int FN_W = 6;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_ADD = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic     a_inv;
    logic     b_inv;
    alu_sel_e sel;
  } alu_ctl_t;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

endpackage

// File: rtl/alu2lvl_decode.sv
module alu2lvl_decode
  import alu2lvl_pkg::*;
(
  input  logic [1:0]      op_class,
  input  logic [FN_W-1:0] func_code,
  output alu_ctl_t        ctl,
  output logic            bad_fn
);

  alu_ctl_t fn_ctl;
  logic     fn_bad;

  // second level: function field to control word
  always_comb begin
    fn_bad = 1'b0;
    fn_ctl = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_ADD};
    case (func_code)
      FN_ADD: fn_ctl = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_ADD};
      FN_SUB: fn_ctl = '{a_inv: 1'b0, b_inv: 1'b1, sel: SEL_ADD};
      FN_AND: fn_ctl = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_AND};
      FN_OR:  fn_ctl = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_OR};
      FN_NOR: fn_ctl = '{a_inv: 1'b1, b_inv: 1'b1, sel: SEL_AND};
      FN_SLT: fn_ctl = '{a_inv: 1'b0, b_inv: 1'b1, sel: SEL_SLT};
      default: fn_bad = 1'b1;
    endcase
  end

  // first level: class code
  always_comb begin
    ctl    = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_ADD};
    bad_fn = 1'b0;
    case (op_class_e'(op_class))
      CLS_ADD:   ctl = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_ADD};
      CLS_SUB:   ctl = '{a_inv: 1'b0, b_inv: 1'b1, sel: SEL_ADD};
      CLS_FUNCT: begin
        ctl    = fn_ctl;
        bad_fn = fn_bad;
      end
      default:   bad_fn = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu2lvl_core.sv
module alu2lvl_core
  import alu2lvl_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_ctl_t       ctl,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         raw_ovf;
  logic         less;

  assign a_eff = ctl.a_inv ? ~a : a;
  assign b_eff = ctl.b_inv ? ~b : b;
  // b_inv doubles as carry-in for two's-complement subtraction
  assign sum   = a_eff + b_eff + {{(W-1){1'b0}}, ctl.b_inv};

  assign raw_ovf = (a_eff[MSB] == b_eff[MSB]) && (sum[MSB] != a_eff[MSB]);
  assign less    = sum[MSB] ^ raw_ovf;

  // overflow is reported only for true add/sub
  assign ovf = raw_ovf && (ctl.sel == SEL_ADD) && !ctl.a_inv;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    always_comb begin
      case (ctl.sel)
        SEL_AND: res[i] = a_eff[i] & b_eff[i];
        SEL_OR:  res[i] = a_eff[i] | b_eff[i];
        SEL_ADD: res[i] = sum[i];
        default: res[i] = less_in;
      endcase
    end
  end

endmodule

// File: rtl/alu2lvl_top.sv
module alu2lvl_top
  import alu2lvl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      op_class,
  input  logic [FN_W-1:0] func_code,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  output logic [W-1:0]    res_q,
  output logic            zero_q,
  output logic            ovf_q,
  output logic            bad_fn_q
);

  alu_ctl_t     ctl;
  logic         bad_fn;
  logic [W-1:0] core_res;
  logic         core_ovf;
  logic [W-1:0] res_n;
  logic         ovf_n;

  alu2lvl_decode u_decode (
    .op_class  (op_class),
    .func_code (func_code),
    .ctl       (ctl),
    .bad_fn    (bad_fn)
  );

  alu2lvl_core #(.W(W)) u_core (
    .ctl (ctl),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (core_res),
    .ovf (core_ovf)
  );

  assign res_n = bad_fn ? '0 : core_res;
  assign ovf_n = core_ovf && !bad_fn;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= '0;
      zero_q   <= 1'b0;
      ovf_q    <= 1'b0;
      bad_fn_q <= 1'b0;
    end else begin
      res_q    <= res_n;
      zero_q   <= (res_n == '0);
      ovf_q    <= ovf_n;
      bad_fn_q <= bad_fn;
    end
  end

endmodule

// File: rtl/alu2lvl_chk.sv
module alu2lvl_chk
  import alu2lvl_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      op_class,
  input logic [FN_W-1:0] func_code,
  input logic [W-1:0]    opnd_a,
  input logic [W-1:0]    opnd_b,
  input logic [W-1:0]    res_q,
  input logic            zero_q,
  input logic            ovf_q,
  input logic            bad_fn_q
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !zero_q && !ovf_q && !bad_fn_q)); // R1

  AST_CLASS_ADD: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b00) |=> (res_q == $past(opnd_a + opnd_b))); // R3

  AST_CLASS_SUB: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b01) |=> (res_q == $past(opnd_a - opnd_b))); // R4

  AST_NOR_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && func_code == 6'd39) |=> (res_q == ~$past(opnd_a | opnd_b))); // R6

  AST_SLT_SIGNED: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && func_code == 6'd42) |=>
      (res_q == {{(W-1){1'b0}}, $past($signed(opnd_a) < $signed(opnd_b))})); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (res_q == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && (func_code == 6'd36 || func_code == 6'd37 ||
     func_code == 6'd39 || func_code == 6'd42)) |=> !ovf_q); // R9

  AST_RSVD_CLASS: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b11) |=> (bad_fn_q && !ovf_q && res_q == '0 && zero_q)); // R10

endmodule

bind alu2lvl_top alu2lvl_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_class  (op_class),
  .func_code (func_code),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .res_q     (res_q),
  .zero_q    (zero_q),
  .ovf_q     (ovf_q),
  .bad_fn_q  (bad_fn_q)
);

// File: tb/alu2lvl_top_bench.sv
`timescale 1ns/1ps
module alu2lvl_top_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_class = 2'b00;
  logic [5:0]   func_code = 6'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] res_q;
  logic         zero_q, ovf_q, bad_fn_q;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  alu2lvl_top #(.W(W)) u_alu2lvl_top (
    .clk(clk), .rst(rst), .op_class(op_class), .func_code(func_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_q(res_q), .zero_q(zero_q),
    .ovf_q(ovf_q), .bad_fn_q(bad_fn_q)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // apply one operation, wait one registered stage, compare to spec model
  task automatic run(string req, logic [1:0] cls, logic [5:0] fn,
                     logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] e_res;
    logic         e_ovf, e_bad;
    logic [W-1:0] s, d;
    s = a + b;
    d = a - b;
    e_res = '0; e_ovf = 1'b0; e_bad = 1'b0;
    case (cls)
      2'b00: begin e_res = s; e_ovf = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]); end
      2'b01: begin e_res = d; e_ovf = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]); end
      2'b10: case (fn)
        6'd32: begin e_res = s; e_ovf = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]); end
        6'd34: begin e_res = d; e_ovf = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]); end
        6'd36: e_res = a & b;
        6'd37: e_res = a | b;
        6'd39: e_res = ~(a | b);
        6'd42: e_res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        default: e_bad = 1'b1;
      endcase
      default: e_bad = 1'b1;
    endcase
    @(negedge clk);
    op_class = cls; func_code = fn; opnd_a = a; opnd_b = b;
    @(negedge clk);
    check(req, "result", res_q, e_res);
    check(req, "zero",   {{(W-1){1'b0}}, zero_q},   {{(W-1){1'b0}}, (e_res == '0)});
    check(req, "ovf",    {{(W-1){1'b0}}, ovf_q},    {{(W-1){1'b0}}, e_ovf});
    check(req, "bad_fn", {{(W-1){1'b0}}, bad_fn_q}, {{(W-1){1'b0}}, e_bad});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "result", res_q, '0);
    check("R1", "flags", {{(W-3){1'b0}}, zero_q, ovf_q, bad_fn_q}, '0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    @(negedge clk);
    op_class = 2'b00; func_code = 6'd0; opnd_a = 32'd5; opnd_b = 32'd7;
    @(posedge clk); #1;
    check("R2", "after one edge", res_q, 32'd12);
    @(negedge clk);
    op_class = 2'b00; opnd_a = 32'd100; opnd_b = 32'd1;
    #1;
    check("R2", "held before edge", res_q, 32'd12);
    @(posedge clk); #1;
    check("R2", "next edge", res_q, 32'd101);
  endtask

  task automatic t_fixed_classes;
    run("R3", 2'b00, 6'd34, 32'd10, 32'd3);
    run("R3", 2'b00, 6'd36, 32'hFFFF_FFFF, 32'd1);
    run("R4", 2'b01, 6'd32, 32'd10, 32'd3);
    run("R4", 2'b01, 6'd42, 32'd3, 32'd10);
    run("R4", 2'b01, 6'd0, 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic t_rtype_arith;
    run("R5", 2'b10, 6'd32, 32'h0000_FFFF, 32'h0001_0001);
    run("R5", 2'b10, 6'd34, 32'h0000_0001, 32'h0000_0002);
  endtask

  task automatic t_rtype_logic;
    run("R6", 2'b10, 6'd36, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    run("R6", 2'b10, 6'd37, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    run("R6", 2'b10, 6'd39, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    run("R6", 2'b10, 6'd39, 32'h0, 32'h0);
  endtask

  task automatic t_slt;
    run("R7", 2'b10, 6'd42, 32'd3, 32'd9);
    run("R7", 2'b10, 6'd42, 32'd9, 32'd3);
    run("R7", 2'b10, 6'd42, 32'hFFFF_FFFF, 32'd1);
    run("R7", 2'b10, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R7", 2'b10, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000);
    run("R7", 2'b10, 6'd42, 32'd4, 32'd4);
  endtask

  task automatic t_zero;
    run("R8", 2'b01, 6'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run("R8", 2'b10, 6'd36, 32'hAAAA_AAAA, 32'h5555_5555);
    run("R8", 2'b00, 6'd0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_overflow;
    run("R9", 2'b00, 6'd0, 32'h7FFF_FFFF, 32'd1);
    run("R9", 2'b01, 6'd0, 32'h8000_0000, 32'd1);
    run("R9", 2'b10, 6'd32, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R9", 2'b10, 6'd34, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R9", 2'b10, 6'd39, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run("R9", 2'b10, 6'd42, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_invalid;
    run("R10", 2'b11, 6'd32, 32'd5, 32'd6);
    run("R10", 2'b10, 6'd0, 32'd5, 32'd6);
    run("R10", 2'b10, 6'd33, 32'h7FFF_FFFF, 32'd1);
    run("R10", 2'b10, 6'd38, 32'd5, 32'd6);
    run("R10", 2'b10, 6'd43, 32'd1, 32'd2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_fixed_classes();
        t_rtype_arith();
        t_rtype_logic();
        t_slt();
        t_zero();
        t_overflow();
        t_invalid();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule